// File: doc/BRIEF.md
# SDRAM Open-Page Close Timer

This block tells an SDRAM controller when it has to close the row that is currently open. Two programmable timers run while a page is open. The row timer measures the time since the activate. Its limit is given in coarse units of 64 clocks, which suits the long maximum row-active window. The burst timer measures the time since the most recent activate or column (read or write) command. Every column command restarts it, so a page that is still being used stays open.

When either timer expires, the block raises a registered close-page request. The command sequencer answers it by issuing a precharge. The request is never raised while a memory access is in progress or in a cycle that carries a command. In those cases it waits for the first free cycle. Once raised, it stays high until the sequencer reports that the precharge has been accepted. That acceptance also stops and clears both timers, and they start again on the next activate.

A zero in either limit field turns page mode off. In that case the page is closed as soon as the first access after the activate has finished.

Top module: `page_close_timer`

## Requirements
- R1: After a synchronous reset, `close_req_o` is low, and it stays low until an activate has been seen.
- R2: With page mode on and no column command after the activate, `close_req_o` rises exactly `row_limit_i`×2^SCALE_LOG2 rising edges after the edge that samples `act_i`, provided the burst limit is larger than that.
- R3: With page mode on and no column command after the activate, `close_req_o` rises exactly `burst_limit_i` edges after the activate edge, provided the row span is larger than that.
- R4: Each column command (`col_i` high at an edge) restarts the burst timer. The request then rises exactly `burst_limit_i` edges after the last column edge.
- R5: When `row_limit_i` is zero, no request is made before a column command. After the first column command, `close_req_o` rises at the first edge that samples `busy_i` low and `col_i` low.
- R6: When `burst_limit_i` is zero, the behaviour is the same as in R5.
- R7: The request never rises at an edge that samples `busy_i` high. An expiry that falls inside an access is held back and the request rises at the first edge where `busy_i` is low.
- R8: Once high, `close_req_o` stays high until an edge samples `pre_ack_i`. It is low directly after that edge.
- R9: After a precharge has been accepted, no request rises until the next activate, because both timers are stopped.
- R10: An edge that samples `col_i` or `act_i` high never raises the request. A column command that arrives in the cycle of a burst expiry delays the request by a full burst interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| act_i | input | 1 | A row activate is issued this cycle |
| col_i | input | 1 | A read or write command is issued this cycle |
| busy_i | input | 1 | A memory access is in progress |
| pre_ack_i | input | 1 | The precharge that closes the page is accepted this cycle |
| row_limit_i | input | ROW_W | Row-active limit in units of 2^SCALE_LOG2 clocks; zero turns page mode off |
| burst_limit_i | input | BURST_W | Clocks from the last activate or column command to a close; zero turns page mode off |
| close_req_o | output | 1 | Registered close-page request, held until the precharge is accepted |

## Verification
The hardest situations to reach are the collisions: a timer expiring in the same cycle as a column command, or while an access holds `busy_i` high.

The stimulus creates them on purpose. It counts edges from the activate to land a column command exactly on the cycle in which the burst timer reaches its limit. It also holds `busy_i` high across the row expiry and then releases it on a known edge.

The bench runs with a small configuration (a scale of 4, a 5-bit burst field). Sweeping every burst limit and a range of row limits then takes only a few thousand cycles. The expected edge counts follow directly from the limit values.

// File: rtl/pct_pkg.sv
package pct_pkg;
  // Control state kept next to the two interval counters.
  typedef struct packed {
    logic open;      // a row is open
    logic accessed;  // a column command was seen since the activate
    logic close;     // close-page request
  } pct_state_t;
endpackage

// File: rtl/pct_interval_counter.sv
// Saturating elapsed-cycle counter; value 0 means stopped.
module pct_interval_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= CNT_ONE;
    end else if (cnt_q != '0 && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + CNT_ONE;
    end
  end

  assign expired = (cnt_q != '0) && (cnt_q >= limit);
endmodule

// File: rtl/page_close_timer.sv
module page_close_timer #(
  parameter int ROW_W      = 8,
  parameter int SCALE_LOG2 = 6,
  parameter int BURST_W    = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               act_i,
  input  logic               col_i,
  input  logic               busy_i,
  input  logic               pre_ack_i,
  input  logic [ROW_W-1:0]   row_limit_i,
  input  logic [BURST_W-1:0] burst_limit_i,
  output logic               close_req_o
);
  import pct_pkg::*;

  localparam int ROW_CNT_W = ROW_W + SCALE_LOG2;

  pct_state_t             st_q;
  logic [ROW_CNT_W-1:0]   row_span;
  logic                   row_expired;
  logic                   burst_expired;
  logic                   page_mode_on;
  logic                   free_cycle;
  logic                   close_due;

  // Coarse row limit scaled up to clocks.
  generate
    if (SCALE_LOG2 > 0) begin : g_scaled
      assign row_span = {row_limit_i, {SCALE_LOG2{1'b0}}};
    end else begin : g_unscaled
      assign row_span = row_limit_i;
    end
  endgenerate

  pct_interval_counter #(.CNT_W(ROW_CNT_W)) i_row_cnt (
    .clk     (clk),
    .rst     (rst),
    .clear   (pre_ack_i),
    .restart (act_i),
    .limit   (row_span),
    .expired (row_expired)
  );

  pct_interval_counter #(.CNT_W(BURST_W)) i_burst_cnt (
    .clk     (clk),
    .rst     (rst),
    .clear   (pre_ack_i),
    .restart (act_i | col_i),
    .limit   (burst_limit_i),
    .expired (burst_expired)
  );

  assign page_mode_on = (|row_limit_i) && (|burst_limit_i);
  assign free_cycle   = st_q.open && !busy_i && !col_i && !act_i;
  assign close_due    = free_cycle &&
                        (page_mode_on ? (row_expired || burst_expired) : st_q.accessed);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
    end else if (pre_ack_i) begin
      st_q <= '0;
    end else begin
      st_q.open     <= st_q.open | act_i;
      st_q.accessed <= act_i ? 1'b0 : (st_q.accessed | (col_i & st_q.open));
      st_q.close    <= st_q.close | close_due;
    end
  end

  assign close_req_o = st_q.close;
endmodule

// File: rtl/pct_checker.sv
module pct_checker (
  input logic clk,
  input logic rst,
  input logic act_i,
  input logic col_i,
  input logic busy_i,
  input logic pre_ack_i,
  input logic close_req_o
);
  // Page-open state rebuilt from the ports alone.
  logic seen_open_q;
  always_ff @(posedge clk) begin
    if (rst || pre_ack_i) seen_open_q <= 1'b0;
    else if (act_i)       seen_open_q <= 1'b1;
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    close_req_o && !pre_ack_i |=> close_req_o); // R8
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
    pre_ack_i |=> !close_req_o); // R8
  AST_NO_RISE_BUSY: assert property (@(posedge clk) disable iff (rst)
    !close_req_o && busy_i |=> !close_req_o); // R7
  AST_NO_RISE_CMD: assert property (@(posedge clk) disable iff (rst)
    !close_req_o && (col_i || act_i) |=> !close_req_o); // R10
  AST_NO_RISE_CLOSED: assert property (@(posedge clk) disable iff (rst)
    !close_req_o && !seen_open_q && !act_i |=> !close_req_o); // R9
endmodule

bind page_close_timer pct_checker i_pct_checker (
  .clk         (clk),
  .rst         (rst),
  .act_i       (act_i),
  .col_i       (col_i),
  .busy_i      (busy_i),
  .pre_ack_i   (pre_ack_i),
  .close_req_o (close_req_o)
);

// File: tb/test_page_close_timer.sv
module test_page_close_timer;
  localparam int ROW_W = 4;
  localparam int SCALE_LOG2 = 2;
  localparam int BURST_W = 5;
  localparam int SCALE = 1 << SCALE_LOG2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic act = 1'b0, col = 1'b0, busy = 1'b0, pre_ack = 1'b0;
  logic [ROW_W-1:0]   row_lim = '0;
  logic [BURST_W-1:0] bst_lim = '0;
  logic close_req;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  page_close_timer #(.ROW_W(ROW_W), .SCALE_LOG2(SCALE_LOG2), .BURST_W(BURST_W)) i_page_close_timer (
    .clk(clk), .rst(rst), .act_i(act), .col_i(col), .busy_i(busy),
    .pre_ack_i(pre_ack), .row_limit_i(row_lim), .burst_limit_i(bst_lim),
    .close_req_o(close_req)
  );

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_act();
    act = 1'b1; tick(); act = 1'b0;
  endtask

  task automatic do_col();
    col = 1'b1; tick(); col = 1'b0;
  endtask

  task automatic count_rise(input int maxc, output int n);
    n = 0;
    for (int i = 1; i <= maxc; i++) begin
      tick();
      if (close_req) begin n = i; return; end
    end
  endtask

  task automatic do_ack();
    pre_ack = 1'b1; tick(); pre_ack = 1'b0;
    check(close_req == 1'b0, "R8 drop after ack", close_req, 0);
  endtask

  task automatic quiet(input int cycles, input string req);
    bit bad = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      tick();
      if (close_req) bad = 1'b1;
    end
    check(!bad, req, bad, 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    tick(); tick(); tick();
    rst = 1'b0;
    check(close_req == 1'b0, "R1 reset value", close_req, 0);
    row_lim = 4'd1; bst_lim = 5'd2;
    quiet(20, "R1 no request before activate");

    // R2: row interval sweep
    bst_lim = 5'd31;
    for (int r = 1; r <= 7; r++) begin
      row_lim = ROW_W'(r);
      do_act();
      count_rise(100, n);
      check(n == r * SCALE, "R2 row interval", n, r * SCALE);
      quiet(0, "R8");
      tick(); tick(); tick();
      check(close_req == 1'b1, "R8 request held", close_req, 1);
      do_ack();
      quiet(40, "R9 timers stopped after ack");
    end

    // R3: burst interval sweep
    row_lim = 4'd15;
    for (int b = 1; b <= 31; b++) begin
      bst_lim = BURST_W'(b);
      do_act();
      count_rise(100, n);
      check(n == b, "R3 burst interval", n, b);
      do_ack();
    end

    // R4: column commands restart the burst timer
    bst_lim = 5'd12;
    do_act();
    quiet(5, "R4 before first column");
    do_col();
    for (int k = 0; k < 3; k++) begin
      quiet(7, "R4 between column commands");
      do_col();
    end
    count_rise(100, n);
    check(n == 12, "R4 reload from last column", n, 12);
    do_ack();

    // R10: column at the expiry cycle
    bst_lim = 5'd4;
    do_act();
    tick(); tick(); tick();
    col = 1'b1; tick(); col = 1'b0;
    check(close_req == 1'b0, "R10 column blocks request", close_req, 0);
    count_rise(100, n);
    check(n == 4, "R10 full burst after late column", n, 4);
    do_ack();

    // R5: row limit zero
    row_lim = 4'd0; bst_lim = 5'd31;
    do_act();
    quiet(10, "R5 no request before access");
    do_col();
    count_rise(10, n);
    check(n == 1, "R5 close after access", n, 1);
    do_ack();

    // R6: burst limit zero
    row_lim = 4'd15; bst_lim = 5'd0;
    do_act();
    quiet(10, "R6 no request before access");
    do_col();
    count_rise(10, n);
    check(n == 1, "R6 close after access", n, 1);
    do_ack();

    // R7: disabled mode with a long access
    row_lim = 4'd0; bst_lim = 5'd31;
    do_act();
    busy = 1'b1;
    do_col();
    tick();
    check(close_req == 1'b0, "R7 busy holds request", close_req, 0);
    tick();
    check(close_req == 1'b0, "R7 busy holds request", close_req, 0);
    busy = 1'b0;
    count_rise(10, n);
    check(n == 1, "R7 request after busy ends", n, 1);
    do_ack();

    // R7: row expiry during an access
    row_lim = 4'd1; bst_lim = 5'd31;
    busy = 1'b1;
    do_act();
    quiet(6, "R7 expiry deferred while busy");
    busy = 1'b0;
    count_rise(10, n);
    check(n == 1, "R7 deferred request timing", n, 1);
    do_ack();
    quiet(40, "R9 stopped after deferred close");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule